// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host with a 32-bit register bus reach a small subsystem register space that uses byte addresses. The host cannot address the subsystem directly. It programs a control word with the subsystem address, the direction, the access size and the byte lanes. It then moves data through two 32-bit data registers. A busy bit in the control word stays set while the bridge runs the transfer on the subsystem side. The transfer takes a fixed number of cycles.

A read starts as soon as a control word with the read direction is written. Its result lands in the data registers when busy clears. A write is split in two steps. First a control word with the write direction is written, which starts nothing. The write then launches when the lower data register is written.

Two interrupt sources are gathered into one output:
- a completed-transfer event from the bridge itself;
- a rising edge on an interrupt line from the subsystem.

Each source has an enable bit and a flag bit. A flag bit is cleared by writing 1 to it.

Both edges of the block use plain strobes, not valid/ready handshakes. The host issues one read or one write per cycle and is never stalled; it learns progress by polling busy. The subsystem is always ready and gets exactly one strobe per transfer. Because the latency is fixed, neither side has back-pressure to express.

Top module: `irab_bridge`

## Requirements
- R1: After reset, the following all read 0: the control word (busy included), both data registers, the enable register and the flag register. `irq_o` is 0 and no subsystem strobe is issued.
- R2: A read of host offset 0x00 returns the parameter `ID_VALUE` (default 0x49520001).
- R3: `host_rdata` is registered. It takes the value selected by `host_addr` on the clock edge where `host_rd` is sampled high and holds it otherwise. Offsets other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 read as 0, and so do offsets that are not word aligned.
- R4: The control word at offset 0x04 has this layout:

  | Bit(s) | Field |
  |---|---|
  | 31 | busy |
  | 25 | size |
  | 24 | direction (1 = read) |
  | 23:20 | upper-word byte enables |
  | 19:16 | lower-word byte enables |
  | 7:0 | subsystem address |

  All other bits read 0. The written fields read back unchanged.
- R5: Writing the control word with bit 24 = 1 while idle starts a read. Busy reads 1 for exactly 4 cycles (`LATENCY`). One `sub_stb` is issued with `sub_we` = 0 in the last busy cycle. `sub_rdata[31:0]` is captured into lower data (offset 0x08) and `sub_rdata[63:32]` into upper data (offset 0x0C).
- R6: Writing the control word with bit 24 = 0, or writing upper data, starts no transfer. Writing lower data while idle, with the stored direction being write, starts a write. The write lasts the same 4 busy cycles and issues one `sub_stb` with these values:
  - `sub_we` = 1;
  - `sub_addr` = the stored address;
  - `sub_be` = {upper enables, lower enables};
  - `sub_wdata` = {upper data, lower data}.
- R7: While busy, host writes to the control word, lower data or upper data have no effect and start no transfer.
- R8: Flag bit 0 (offset 0x14) sets when a transfer completes. Flag bit 1 sets on a rising edge of `sub_irq`. A level held high does not set the flag again after it has been cleared.
- R9: Writing the flag register clears every bit written as 1 and leaves bits written as 0 unchanged.
- R10: The enable register (offset 0x10) holds bits 1:0, using the same bit assignment as the flags. `irq_o` is 1 exactly when some flag bit and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 6 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| sub_stb | output | 1 | One-cycle subsystem access strobe |
| sub_we | output | 1 | Subsystem access is a write |
| sub_size | output | 1 | Size field of the control word |
| sub_addr | output | SUB_AW | Subsystem register address |
| sub_be | output | 8 | Byte enables, upper lanes in bits 7:4 |
| sub_wdata | output | 64 | Subsystem write data {upper, lower} |
| sub_rdata | input | 64 | Subsystem read data, valid while `sub_stb` is high |
| sub_irq | input | 1 | Subsystem interrupt level |
| irq_o | output | 1 | Combined interrupt |

## Verification
Results arrive on a fixed schedule:
- A host read answers one clock edge after `host_rd` is sampled.
- A triggering write sets busy on its own edge. The strobe comes in the fourth busy cycle, and the captured read data appears on the edge that clears busy.
- A flag change shows on `irq_o` right after the edge that made it.

The bench drives inputs and samples outputs on the falling edge. It polls the control word with back-to-back reads, one per cycle, starting on the cycle after the trigger. It counts busy replies until the first idle one and expects exactly 4. It records every `sub_stb` and its fields at the edge where the bridge presents them.

// File: rtl/irab_pkg.sv
package irab_pkg;

  localparam int HOST_AW = 6;

  // host register offsets
  localparam logic [HOST_AW-1:0] OFS_ID    = 6'h00;
  localparam logic [HOST_AW-1:0] OFS_CTRL  = 6'h04;
  localparam logic [HOST_AW-1:0] OFS_LDATA = 6'h08;
  localparam logic [HOST_AW-1:0] OFS_UDATA = 6'h0C;
  localparam logic [HOST_AW-1:0] OFS_IEN   = 6'h10;
  localparam logic [HOST_AW-1:0] OFS_IFLG  = 6'h14;

  // control word bit positions
  localparam int CW_BUSY  = 31;
  localparam int CW_SIZE  = 25;
  localparam int CW_DIR   = 24;
  localparam int CW_BEU_L = 20;
  localparam int CW_BEL_L = 16;

  // interrupt bit positions
  localparam int IB_IFACE = 0;
  localparam int IB_SUB   = 1;
  localparam int NUM_IRQ  = 2;

  typedef enum logic [2:0] {
    SEL_ID, SEL_CTRL, SEL_LDATA, SEL_UDATA, SEL_IEN, SEL_IFLG, SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [HOST_AW-1:0] a);
    case (a)
      OFS_ID:    return SEL_ID;
      OFS_CTRL:  return SEL_CTRL;
      OFS_LDATA: return SEL_LDATA;
      OFS_UDATA: return SEL_UDATA;
      OFS_IEN:   return SEL_IEN;
      OFS_IFLG:  return SEL_IFLG;
      default:   return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irab_xfer_seq.sv
module irab_xfer_seq #(
  parameter int LATENCY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_we,
  output logic busy,
  output logic stb,
  output logic stb_we
);
  localparam int CW = $clog2(LATENCY + 1);
  localparam logic [CW-1:0] LOAD = CW'(LATENCY - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          we_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      we_q   <= 1'b0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= LOAD;
        we_q   <= start_we;
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy   = busy_q;
  assign stb    = busy_q && (cnt_q == '0);
  assign stb_we = we_q;

  // R5
  strobe_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !busy);

  // R5
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !stb) |=> busy);

  // R7
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);

endmodule

// File: rtl/irab_ctrl_regs.sv
module irab_ctrl_regs
  import irab_pkg::*;
#(
  parameter int SUB_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_ldata,
  input  logic              wr_udata,
  input  logic [31:0]       wdata,
  input  logic              busy,
  input  logic              done,
  input  logic              done_we,
  input  logic [63:0]       rd_data,
  output logic [SUB_AW-1:0] addr_q,
  output logic              dir_q,
  output logic              size_q,
  output logic [3:0]        beu_q,
  output logic [3:0]        bel_q,
  output logic [31:0]       ldata_q,
  output logic [31:0]       udata_q,
  output logic              start,
  output logic              start_we
);
  logic accept;
  assign accept = !busy;

  assign start    = accept && ((wr_ctrl && wdata[CW_DIR]) || (wr_ldata && !dir_q));
  assign start_we = wr_ldata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      dir_q  <= 1'b0;
      size_q <= 1'b0;
      beu_q  <= '0;
      bel_q  <= '0;
    end else if (accept && wr_ctrl) begin
      addr_q <= wdata[SUB_AW-1:0];
      dir_q  <= wdata[CW_DIR];
      size_q <= wdata[CW_SIZE];
      beu_q  <= wdata[CW_BEU_L +: 4];
      bel_q  <= wdata[CW_BEL_L +: 4];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ldata_q <= '0;
      udata_q <= '0;
    end else if (done && !done_we) begin
      ldata_q <= rd_data[31:0];
      udata_q <= rd_data[63:32];
    end else if (accept) begin
      if (wr_ldata) ldata_q <= wdata;
      if (wr_udata) udata_q <= wdata;
    end
  end

  // R7
  ctrl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_ctrl) |=> ($stable(addr_q) && $stable(dir_q)));

  // R7
  ldata_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && wr_ldata) |=> $stable(ldata_q));

  // R6
  wr_dir_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wdata[CW_DIR]) |-> !start);

endmodule

// File: rtl/irab_irq_unit.sv
module irab_irq_unit
  import irab_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ien,
  input  logic               wr_iflg,
  input  logic [NUM_IRQ-1:0] wbits,
  input  logic               sub_irq,
  input  logic               if_event,
  output logic [NUM_IRQ-1:0] ien_q,
  output logic [NUM_IRQ-1:0] iflg_q,
  output logic               irq_o
);
  logic               sub_irq_q;
  logic               sub_rise;
  logic [NUM_IRQ-1:0] set_v;
  logic [NUM_IRQ-1:0] clr_v;

  assign sub_rise = sub_irq && !sub_irq_q;

  always_comb begin
    set_v           = '0;
    set_v[IB_SUB]   = sub_rise;
    set_v[IB_IFACE] = if_event;
    clr_v           = wr_iflg ? wbits : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_irq_q <= 1'b0;
      ien_q     <= '0;
      iflg_q    <= '0;
    end else begin
      sub_irq_q <= sub_irq;
      iflg_q    <= (iflg_q & ~clr_v) | set_v;
      if (wr_ien) ien_q <= wbits;
    end
  end

  assign irq_o = |(iflg_q & ien_q);

  // R8
  sub_edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_rise |=> iflg_q[IB_SUB]);

  // R8
  done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    if_event |=> iflg_q[IB_IFACE]);

  // R9
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_iflg && wbits[IB_SUB] && !sub_rise) |=> !iflg_q[IB_SUB]);

  // R9
  w0_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_iflg && !wbits[IB_SUB] && iflg_q[IB_SUB]) |=> iflg_q[IB_SUB]);

endmodule

// File: rtl/irab_bridge.sv
module irab_bridge
  import irab_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h4952_0001,
  parameter int          SUB_AW   = 8,
  parameter int          LATENCY  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [5:0]        host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              sub_stb,
  output logic              sub_we,
  output logic              sub_size,
  output logic [SUB_AW-1:0] sub_addr,
  output logic [7:0]        sub_be,
  output logic [63:0]       sub_wdata,
  input  logic [63:0]       sub_rdata,
  input  logic              sub_irq,
  output logic              irq_o
);
  reg_sel_e sel;
  assign sel = decode_ofs(host_addr);

  logic wr_ctrl, wr_ldata, wr_udata, wr_ien, wr_iflg;
  assign wr_ctrl  = host_wr && (sel == SEL_CTRL);
  assign wr_ldata = host_wr && (sel == SEL_LDATA);
  assign wr_udata = host_wr && (sel == SEL_UDATA);
  assign wr_ien   = host_wr && (sel == SEL_IEN);
  assign wr_iflg  = host_wr && (sel == SEL_IFLG);

  logic              busy, start, start_we, stb, stb_we;
  logic [SUB_AW-1:0] addr_q;
  logic              dir_q, size_q;
  logic [3:0]        beu_q, bel_q;
  logic [31:0]       ldata_q, udata_q;
  logic [NUM_IRQ-1:0] ien_q, iflg_q;

  irab_ctrl_regs #(.SUB_AW(SUB_AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (wr_ctrl),
    .wr_ldata (wr_ldata),
    .wr_udata (wr_udata),
    .wdata    (host_wdata),
    .busy     (busy),
    .done     (stb),
    .done_we  (stb_we),
    .rd_data  (sub_rdata),
    .addr_q   (addr_q),
    .dir_q    (dir_q),
    .size_q   (size_q),
    .beu_q    (beu_q),
    .bel_q    (bel_q),
    .ldata_q  (ldata_q),
    .udata_q  (udata_q),
    .start    (start),
    .start_we (start_we)
  );

  irab_xfer_seq #(.LATENCY(LATENCY)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .start_we (start_we),
    .busy     (busy),
    .stb      (stb),
    .stb_we   (stb_we)
  );

  irab_irq_unit u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ien   (wr_ien),
    .wr_iflg  (wr_iflg),
    .wbits    (host_wdata[NUM_IRQ-1:0]),
    .sub_irq  (sub_irq),
    .if_event (stb),
    .ien_q    (ien_q),
    .iflg_q   (iflg_q),
    .irq_o    (irq_o)
  );

  assign sub_stb   = stb;
  assign sub_we    = stb_we;
  assign sub_size  = size_q;
  assign sub_addr  = addr_q;
  assign sub_be    = {beu_q, bel_q};
  assign sub_wdata = {udata_q, ldata_q};

  logic [31:0] ctrl_word;
  always_comb begin
    ctrl_word                   = '0;
    ctrl_word[15:0]             = 16'(addr_q);
    ctrl_word[CW_BEL_L +: 4]    = bel_q;
    ctrl_word[CW_BEU_L +: 4]    = beu_q;
    ctrl_word[CW_DIR]           = dir_q;
    ctrl_word[CW_SIZE]          = size_q;
    ctrl_word[CW_BUSY]          = busy;
  end

  logic [31:0] rd_mux;
  always_comb begin
    case (sel)
      SEL_ID:    rd_mux = ID_VALUE;
      SEL_CTRL:  rd_mux = ctrl_word;
      SEL_LDATA: rd_mux = ldata_q;
      SEL_UDATA: rd_mux = udata_q;
      SEL_IEN:   rd_mux = 32'(ien_q);
      SEL_IFLG:  rd_mux = 32'(iflg_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_mux;
  end

  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));

  // R5
  stb_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_stb |-> $past(busy));

endmodule

// File: tb/irab_bridge_test.sv
module irab_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        sub_stb, sub_we, sub_size;
  logic [7:0]  sub_addr, sub_be;
  logic [63:0] sub_wdata, sub_rdata;
  logic        sub_irq = 1'b0;
  logic        irq_o;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  irab_bridge uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sub_stb(sub_stb), .sub_we(sub_we), .sub_size(sub_size),
    .sub_addr(sub_addr), .sub_be(sub_be), .sub_wdata(sub_wdata),
    .sub_rdata(sub_rdata), .sub_irq(sub_irq), .irq_o(irq_o)
  );

  // subsystem model: byte-wide registers, lane 0 written
  logic [7:0]  mem [256];
  int          stb_cnt = 0;
  logic        last_we;
  logic [7:0]  last_addr, last_be;
  logic [63:0] last_wdata;

  assign sub_rdata = {16'hBEEF, 8'h00, sub_addr, 24'h0, mem[sub_addr]};

  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;

  always @(posedge clk) begin
    if (sub_stb) begin
      stb_cnt    <= stb_cnt + 1;
      last_we    <= sub_we;
      last_addr  <= sub_addr;
      last_be    <= sub_be;
      last_wdata <= sub_wdata;
      if (sub_we && sub_be[0]) mem[sub_addr] <= sub_wdata[7:0];
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [5:0] a, input logic [31:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hr(input logic [5:0] a, output logic [31:0] d);
    host_rd = 1'b1; host_addr = a;
    @(posedge clk); @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  // back-to-back control reads; count replies with busy set
  task automatic poll_busy(output int n);
    n = 0;
    host_rd = 1'b1; host_addr = 6'h04;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); @(negedge clk);
      if (host_rdata[31]) n++;
      else break;
    end
    host_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    hr(6'h04, d); chk("R1 ctrl", d, 0);
    hr(6'h08, d); chk("R1 ldata", d, 0);
    hr(6'h10, d); chk("R1 ien", d, 0);
    hr(6'h14, d); chk("R1 iflg", d, 0);
    chk("R1 irq_o", irq_o, 0);
    chk("R1 no strobe", stb_cnt, 0);
  endtask

  task automatic t_id();
    logic [31:0] d;
    hr(6'h00, d); chk("R2 id", d, 32'h4952_0001);
    hr(6'h18, d); chk("R3 undefined offset", d, 0);
    hr(6'h05, d); chk("R3 misaligned offset", d, 0);
    hr(6'h00, d);
    @(posedge clk); @(negedge clk);
    chk("R3 rdata holds", host_rdata, 32'h4952_0001);
  endtask

  task automatic t_write();
    logic [31:0] d; int n;
    hw(6'h04, 32'h0201_0015);        // size 1, dir write, beu 0, bel 1, addr 0x15
    hr(6'h04, d); chk("R4 ctrl echo", d, 32'h0201_0015);
    hw(6'h0C, 32'h1122_3344);
    repeat (6) @(negedge clk);
    chk("R6 no start before lower data", stb_cnt, 0);
    hw(6'h08, 32'h0000_0037);
    poll_busy(n); chk("R6 write busy cycles", n, 4);
    chk("R6 one strobe", stb_cnt, 1);
    chk("R6 we", last_we, 1);
    chk("R6 addr", last_addr, 8'h15);
    chk("R6 be", last_be, 8'h01);
    chk("R6 wdata", last_wdata, 64'h1122_3344_0000_0037);
    chk("R6 subsystem stored", mem[8'h15], 8'h37);
  endtask

  task automatic t_read();
    logic [31:0] d; int n;
    hw(6'h04, 32'h0100_0015);
    poll_busy(n); chk("R5 read busy cycles", n, 4);
    chk("R5 one strobe", stb_cnt, 2);
    chk("R5 we low", last_we, 0);
    hr(6'h08, d); chk("R5 lower data", d, 32'h0000_0037);
    hr(6'h0C, d); chk("R5 upper data", d, 32'hBEEF_0015);
    hr(6'h04, d); chk("R4 ctrl idle", d, 32'h0100_0015);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d; int n;
    hw(6'h04, 32'h0001_0015);
    hw(6'h08, 32'h0000_0055);        // starts the write
    hw(6'h04, 32'h0100_0022);        // ignored (busy)
    hw(6'h08, 32'h0000_00AA);        // ignored (busy)
    poll_busy(n); chk("R7 busy remaining", n, 2);
    chk("R7 single strobe", stb_cnt, 3);
    hr(6'h04, d); chk("R7 ctrl unchanged", d, 32'h0001_0015);
    hr(6'h08, d); chk("R7 lower data unchanged", d, 32'h0000_0055);
    chk("R7 subsystem got first value", mem[8'h15], 8'h55);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    hr(6'h14, d); chk("R8 done flag", d, 32'h1);
    chk("R10 masked", irq_o, 0);
    hw(6'h10, 32'h1); chk("R10 enabled", irq_o, 1);
    hr(6'h10, d); chk("R10 ien readback", d, 32'h1);
    hw(6'h14, 32'h0); hr(6'h14, d); chk("R9 write zero keeps", d, 32'h1);
    hw(6'h14, 32'h1); chk("R9 cleared irq", irq_o, 0);
    hr(6'h14, d); chk("R9 cleared flag", d, 0);
    sub_irq = 1'b1;
    @(posedge clk); @(negedge clk);
    hr(6'h14, d); chk("R8 sub flag", d, 32'h2);
    chk("R10 sub masked", irq_o, 0);
    hw(6'h10, 32'h2); chk("R10 sub enabled", irq_o, 1);
    hw(6'h14, 32'h2);
    repeat (3) @(negedge clk);
    hr(6'h14, d); chk("R8 level no reset", d, 0);
    chk("R10 irq low", irq_o, 0);
    sub_irq = 1'b0;
    @(negedge clk);
    sub_irq = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R8 new edge", irq_o, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_id();
    t_write();
    t_read();
    t_busy_ignore();
    t_irq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule